// File: doc/BRIEF.md
# Nibble-Coded 8-bit Processor Core

This block is a small 8-bit processor core that drives a 16-bit address bus, with separate write-data and read-data buses. It expects a synchronous block RAM with one cycle of read latency. Every instruction is one byte. The high nibble picks one of sixteen direct operations. The low nibble supplies four operand bits.

Longer operands are built up in an operand register by positive and negative prefix bytes. All data addressing is base plus operand. The base is either a workspace pointer or the top of a two-entry pointer stack that can be swapped. There is no flags register. Branches test the accumulator value or a lone carry bit directly. A second group of sixteen operations (ALU work, register exchanges and carry control) is reached through an execute operation. Its index comes from the operand.

After reset, the core fetches its first instruction from the address on `rst_ip`. The workspace pointer takes its value from `rst_wp`. These two inputs stand in for an external vector unit. The reset input is asserted asynchronously and released synchronously inside the core.

Top module: `nib_cpu`

## Requirements
- R1: While reset is asserted, `mem_we` stays low. The first fetch after reset reads from `rst_ip`, and the workspace pointer starts at `rst_wp`.
- R2: The operand of a direct instruction is `{K[11:0], nibble}`, where K is the operand register.
  - A positive prefix (high nibble 0) sets K to `{K[11:0], nibble}`.
  - A negative prefix (high nibble 1) sets K to the bitwise inverse of `{K[11:0], nibble}`.
  - Every other instruction leaves K at zero when it completes.
- R3: The direct load and store operations address memory at a base plus the operand.
  - Local load (high nibble 4) and local store (high nibble 6) use the workspace pointer as the base.
  - Non-local load (5) and non-local store (7) use the top entry of the pointer stack.
  - The load-constant operation (3) takes the low byte of the operand.
- R4: Pointer-stack transfers move 16 bits as two bytes, low byte at workspace+operand and high byte at the next address.
  - Load-pointer (8) reads the two bytes into the top entry.
  - Store-pointer (9) writes the top entry out.
  - Indirect index 0 exchanges the top and bottom entries.
- R5: Branches jump to (address of the branch byte + 1 + operand) when their condition holds, and fall through otherwise.
  - High nibble A branches on a nonzero accumulator.
  - High nibble B branches on accumulator bit 7 clear.
  - High nibble C branches on carry clear.
- R6: Subroutine call (F) writes the return address (the byte after the call) at workspace−2 (low byte) and workspace−1 (high byte), lowers the workspace pointer by 2 and jumps relative as in R5. Return (E) first adds the operand to the workspace pointer, then reads the return address from there, raises the workspace pointer by 2 and resumes at that address.
- R7: Workspace adjust (D) adds the operand, signed through prefixes, to the workspace pointer.
- R8: Every load moves the old accumulator A into B before writing A. The indirect operation is selected by the operand's low nibble.

  | Index | Operation |
  |-------|-----------|
  | 1 | swap A and B |
  | 4 | clear C |
  | 5 | set C |
  | 6 | A+B+C |
  | 7 | A+~B+C |
  | 8 | rotate left through C |
  | 9 | shift left, 0 in |
  | 10 | rotate right through C |
  | 11 | arithmetic right shift |
  | 12 | invert A |
  | 13 | AND |
  | 14 | OR |
  | 15 | XOR |

  The two additions leave their ninth bit in C. All four shifts and rotates leave the bit shifted out in C. Logic operations and the inversion leave C unchanged.
- R9: Indirect index 2 exchanges the workspace pointer with `{A, B}`, A being the high byte.
- R10: Cycle costs are as follows, with each prefix adding one cycle.

  | Cycles | Instructions |
  |--------|--------------|
  | 1 | load-constant, prefixes, execute, adjust, any branch |
  | 2 | local or non-local load, local or non-local store |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_ip | input | 16 | Start address of the first fetch |
| rst_wp | input | 16 | Initial workspace pointer |
| mem_addr | output | 16 | Memory address, valid every cycle |
| mem_we | output | 1 | Write strobe for `mem_addr` |
| mem_wdata | output | 8 | Data to write |
| mem_rdata | input | 8 | Read data, one cycle after its address |

## Verification
The bench sweeps every ALU indirect operation over both carry-in values and a grid of operands that covers zero, one and both sign boundaries. It checks the result and the carry out through stores. The carry is captured with a conditional branch, so a design that clobbered or misrouted carry on a shift, or altered it on a logic operation, stores the wrong byte.

Negative prefixes, a backward branch that must run exactly twice, and a call and return that cross a page boundary are all exercised. Off-by-one target arithmetic, a wrong byte order or a missed workspace restore would leave the wrong bytes in the workspace.

Spacing between store strobes measures the cycle cost of each instruction class. A design that wastes a refill cycle on a taken branch, or stalls a load an extra cycle, shows the wrong gap.

// File: rtl/nib_pkg.sv
package nib_pkg;

  typedef enum logic [3:0] {
    OP_PFX, OP_NFX, OP_EXE, OP_LDK, OP_LDL, OP_LDN, OP_STL, OP_STN,
    OP_LDY, OP_STY, OP_BNE, OP_BPL, OP_BNC, OP_ADJ, OP_RTS, OP_JSR
  } dop_e;

  typedef enum logic [3:0] {
    IX_SWP, IX_XAB, IX_XCH, IX_RSV, IX_CLC, IX_SEC, IX_ADC, IX_SBC,
    IX_ROL, IX_ASL, IX_ROR, IX_ASR, IX_CPL, IX_AND, IX_ORL, IX_XOR
  } iop_e;

  typedef enum logic [2:0] {
    ST_BOOT, ST_FILL, ST_EXEC, ST_LDW, ST_RD2, ST_RDF, ST_WR2
  } st_e;

endpackage

// File: rtl/nib_alu.sv
module nib_alu
  import nib_pkg::*;
#(
  parameter int DW = 8
) (
  input  iop_e          op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          c,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic          c_o
);

  logic [DW:0] sum;

  always_comb begin
    a_o = a;
    b_o = b;
    c_o = c;
    sum = '0;
    case (op)
      IX_XAB: begin a_o = b; b_o = a; end
      IX_CLC: c_o = 1'b0;
      IX_SEC: c_o = 1'b1;
      IX_ADC: begin
        sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, c};
        a_o = sum[DW-1:0];
        c_o = sum[DW];
      end
      IX_SBC: begin
        sum = {1'b0, a} + {1'b0, ~b} + {{DW{1'b0}}, c};
        a_o = sum[DW-1:0];
        c_o = sum[DW];
      end
      IX_ROL: begin a_o = {a[DW-2:0], c};       c_o = a[DW-1]; end
      IX_ASL: begin a_o = {a[DW-2:0], 1'b0};    c_o = a[DW-1]; end
      IX_ROR: begin a_o = {c, a[DW-1:1]};       c_o = a[0];    end
      IX_ASR: begin a_o = {a[DW-1], a[DW-1:1]}; c_o = a[0];    end
      IX_CPL: a_o = ~a;
      IX_AND: a_o = a & b;
      IX_ORL: a_o = a | b;
      IX_XOR: a_o = a ^ b;
      default: ;
    endcase
  end

endmodule

// File: rtl/nib_ptrstk.sv
module nib_ptrstk #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          swap,
  output logic [AW-1:0] top
);

  logic [AW-1:0] top_q, bot_q, top_d, bot_d;

  always_comb begin
    top_d = top_q;
    bot_d = bot_q;
    if (swap) begin
      top_d = bot_q;
      bot_d = top_q;
    end else if (ld) begin
      top_d = ld_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      bot_q <= '0;
    end else begin
      top_q <= top_d;
      bot_q <= bot_d;
    end
  end

  assign top = top_q;

  assert_swap_exchanges_R4: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (top_q == $past(bot_q)) && (bot_q == $past(top_q)));

endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
  import nib_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rst_ip,
  input  logic [AW-1:0] rst_wp,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int NB = 4;

  logic [1:0] rsync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_s = rsync[1];

  st_e           st, st_n;
  dop_e          cur, cur_n, dop;
  logic [AW-1:0] ip, ip_n, wp, wp_n, k, k_n, opd, np0, np_val;
  logic [DW-1:0] a, a_n, b, b_n, tmp, tmp_n, alu_a, alu_b;
  logic          c, c_n, alu_c, np_ld, np_swap;
  iop_e          iop;

  assign dop = dop_e'(mem_rdata[DW-1:DW-NB]);
  assign opd = {k[AW-NB-1:0], mem_rdata[NB-1:0]};
  assign iop = iop_e'(opd[NB-1:0]);

  nib_alu #(.DW(DW)) u_alu (
    .op(iop), .a(a), .b(b), .c(c), .a_o(alu_a), .b_o(alu_b), .c_o(alu_c)
  );

  nib_ptrstk #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_s), .ld(np_ld), .ld_val(np_val), .swap(np_swap), .top(np0)
  );

  always_comb begin
    st_n = st;  cur_n = cur; ip_n = ip; wp_n = wp; k_n = k;
    a_n = a;    b_n = b;     c_n = c;   tmp_n = tmp;
    mem_addr = ip; mem_we = 1'b0; mem_wdata = a;
    np_ld = 1'b0; np_val = '0; np_swap = 1'b0;
    case (st)
      ST_BOOT: begin
        mem_addr = rst_ip;
        ip_n = rst_ip + AW'(1);
        wp_n = rst_wp;
        st_n = ST_EXEC;
      end
      ST_FILL: begin
        ip_n = ip + AW'(1);
        st_n = ST_EXEC;
      end
      ST_EXEC: begin
        ip_n  = ip + AW'(1);
        k_n   = '0;
        cur_n = dop;
        case (dop)
          OP_PFX: k_n = opd;
          OP_NFX: k_n = ~opd;
          OP_EXE: begin
            a_n = alu_a; b_n = alu_b; c_n = alu_c;
            if (iop == IX_SWP) np_swap = 1'b1;
            if (iop == IX_XCH) begin
              wp_n = {a, b};
              a_n  = wp[AW-1:DW];
              b_n  = wp[DW-1:0];
            end
          end
          OP_LDK: begin a_n = opd[DW-1:0]; b_n = a; end
          OP_LDL: begin mem_addr = wp + opd;  ip_n = ip; st_n = ST_LDW; end
          OP_LDN: begin mem_addr = np0 + opd; ip_n = ip; st_n = ST_LDW; end
          OP_STL: begin
            mem_addr = wp + opd; mem_we = 1'b1; ip_n = ip; st_n = ST_FILL;
          end
          OP_STN: begin
            mem_addr = np0 + opd; mem_we = 1'b1; ip_n = ip; st_n = ST_FILL;
          end
          OP_LDY: begin
            mem_addr = wp + opd; ip_n = ip; k_n = opd; st_n = ST_RD2;
          end
          OP_STY: begin
            mem_addr = wp + opd; mem_we = 1'b1; mem_wdata = np0[DW-1:0];
            ip_n = ip; k_n = opd; st_n = ST_WR2;
          end
          OP_BNE, OP_BPL, OP_BNC: begin
            if ((dop == OP_BNE && a != '0) || (dop == OP_BPL && !a[DW-1]) ||
                (dop == OP_BNC && !c)) begin
              mem_addr = ip + opd;
              ip_n     = ip + opd + AW'(1);
            end
          end
          OP_ADJ: wp_n = wp + opd;
          OP_RTS: begin
            mem_addr = wp + opd; wp_n = wp + opd; ip_n = ip; st_n = ST_RD2;
          end
          OP_JSR: begin
            mem_addr = wp - AW'(2); mem_we = 1'b1; mem_wdata = ip[DW-1:0];
            ip_n = ip; k_n = opd; st_n = ST_WR2;
          end
          default: ;
        endcase
      end
      ST_LDW: begin
        a_n = mem_rdata; b_n = a;
        ip_n = ip + AW'(1);
        st_n = ST_EXEC;
      end
      ST_RD2: begin
        tmp_n    = mem_rdata;
        mem_addr = (cur == OP_RTS) ? wp + AW'(1) : wp + k + AW'(1);
        st_n     = ST_RDF;
      end
      ST_RDF: begin
        k_n = '0;
        if (cur == OP_RTS) begin
          mem_addr = {mem_rdata, tmp};
          ip_n     = {mem_rdata, tmp} + AW'(1);
          wp_n     = wp + AW'(2);
        end else begin
          np_ld  = 1'b1;
          np_val = {mem_rdata, tmp};
          ip_n   = ip + AW'(1);
        end
        st_n = ST_EXEC;
      end
      ST_WR2: begin
        mem_we = 1'b1;
        k_n    = '0;
        if (cur == OP_JSR) begin
          mem_addr  = wp - AW'(1);
          mem_wdata = ip[AW-1:DW];
          wp_n      = wp - AW'(2);
          ip_n      = ip + k;
        end else begin
          mem_addr  = wp + k + AW'(1);
          mem_wdata = np0[AW-1:DW];
        end
        st_n = ST_FILL;
      end
      default: st_n = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st <= ST_BOOT; cur <= OP_PFX;
      ip <= '0; wp <= '0; k <= '0;
      a <= '0; b <= '0; c <= 1'b0; tmp <= '0;
    end else begin
      st <= st_n; cur <= cur_n;
      ip <= ip_n; wp <= wp_n; k <= k_n;
      a <= a_n; b <= b_n; c <= c_n; tmp <= tmp_n;
    end
  end

  assert_operand_cleared_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_EXEC && dop inside {OP_LDK, OP_ADJ, OP_EXE, OP_BNE, OP_BPL, OP_BNC})
      |=> (k == '0));

  assert_ip_steps_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_EXEC && dop inside {OP_PFX, OP_NFX, OP_LDK, OP_ADJ, OP_EXE})
      |=> (ip == $past(ip) + AW'(1)));

  assert_call_drops_wp_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_WR2 && cur == OP_JSR) |=> (wp == $past(wp) - AW'(2)));

  assert_store_refills_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_EXEC && dop inside {OP_STL, OP_STN}) |=> (st == ST_FILL && !mem_we));

  assert_no_write_at_boot_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_BOOT) |-> !mem_we);

endmodule

// File: tb/tb_nib_cpu.sv
module tb_nib_cpu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rst_ip = '0, rst_wp = '0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  mem [0:1023];

  int nchk = 0, nfail = 0, pc = 0, cyc = 0, we_n = 0;
  int we_t [0:3];
  logic wr_in_rst = 1'b0;

  always #2 clk = ~clk;

  nib_cpu dut (
    .clk(clk), .rst_n(rst_n), .rst_ip(rst_ip), .rst_wp(rst_wp),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      we_n <= 0;
      if (mem_we) wr_in_rst <= 1'b1;
    end else if (mem_we && we_n < 4) begin
      we_t[we_n] <= cyc;
      we_n <= we_n + 1;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
  endtask

  task automatic put(input logic [3:0] op, input logic [3:0] n);
    mem[pc[9:0]] = {op, n};
    pc++;
  endtask

  task automatic ldk(input logic [7:0] v);
    if (v > 8'd15) put(4'h0, v[7:4]);
    put(4'h3, v[3:0]);
  endtask

  task automatic halt();
    put(4'h3, 4'h1); put(4'h1, 4'h0); put(4'hA, 4'hE);
  endtask

  task automatic run(input logic [15:0] ip0, input logic [15:0] wp0, input int n);
    rst_n = 1'b0; rst_ip = ip0; rst_wp = wp0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [8:0] alu_ref(input int op, input logic [7:0] x,
                                         input logic [7:0] y, input logic ci);
    logic [8:0] s;
    case (op)
      1:  s = {ci, y};
      6:  s = {1'b0, x} + {1'b0, y} + {8'd0, ci};
      7:  s = {1'b0, x} + {1'b0, ~y} + {8'd0, ci};
      8:  s = {x[7], x[6:0], ci};
      9:  s = {x[7], x[6:0], 1'b0};
      10: s = {x[0], ci, x[7:1]};
      11: s = {x[0], x[7], x[7:1]};
      12: s = {ci, ~x};
      13: s = {ci, x & y};
      14: s = {ci, x | y};
      default: s = {ci, x ^ y};
    endcase
    return s;
  endfunction

  logic [7:0] vals [0:5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h5A};
  int ops [0:10] = '{1, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15};

  initial begin
    #(4 * 190000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    // R1, R6: start address and workspace from reset inputs; call/return
    clr(); pc = 'h120;
    put(4'hF, 4'hF); put(4'h6, 4'h5); halt();
    pc = 'h130;
    put(4'h1, 4'h0); put(4'hD, 4'hE); put(4'h3, 4'h9); put(4'h6, 4'h0); put(4'hE, 4'h2);
    run(16'h0120, 16'h0300, 40);
    chk("R1 no write during reset", int'(wr_in_rst), 0);
    chk("R6 return low byte", mem['h2FE], 'h21);
    chk("R6 return high byte", mem['h2FF], 'h01);
    chk("R7 local after adjust", mem['h2FC], 'h09);
    chk("R6 workspace restored", mem['h305], 'h09);

    // R2 operand building, R8 load push
    clr(); pc = 0;
    put(4'h1, 4'h0); put(4'h3, 4'h3); put(4'h6, 4'h0);
    put(4'h0, 4'h1); put(4'h0, 4'h2); put(4'h3, 4'h3); put(4'h6, 4'h1);
    put(4'h3, 4'h7); put(4'h6, 4'h2);
    put(4'h1, 4'h1); put(4'h3, 4'h0); put(4'h6, 4'h3);
    ldk(8'h11); put(4'h4, 4'h0); put(4'h2, 4'h1); put(4'h6, 4'h4);
    halt();
    run(16'h0000, 16'h0300, 60);
    chk("R2 negative prefix", mem['h300], 'hF3);
    chk("R2 two prefixes", mem['h301], 'h23);
    chk("R2 operand cleared", mem['h302], 'h07);
    chk("R2 inverted nibble", mem['h303], 'hE0);
    chk("R8 load pushes A to B", mem['h304], 'h11);

    // R3, R4 pointer stack
    clr(); pc = 0;
    mem['h310] = 8'h40; mem['h311] = 8'h02; mem['h312] = 8'h80; mem['h313] = 8'h02;
    mem['h243] = 8'h77;
    put(4'h0, 4'h1); put(4'h8, 4'h0); put(4'h5, 4'h3); put(4'h7, 4'h5);
    put(4'h2, 4'h0); put(4'h0, 4'h1); put(4'h8, 4'h2); put(4'h7, 4'h0);
    put(4'h2, 4'h0); put(4'h0, 4'h1); put(4'h9, 4'h4);
    put(4'h2, 4'h0); put(4'h0, 4'h1); put(4'h9, 4'h6);
    halt();
    run(16'h0000, 16'h0300, 60);
    chk("R3 non-local store", mem['h245], 'h77);
    chk("R4 reloaded top", mem['h280], 'h77);
    chk("R4 store low", mem['h314], 'h40);
    chk("R4 store high", mem['h315], 'h02);
    chk("R4 swapped low", mem['h316], 'h80);
    chk("R4 swapped high", mem['h317], 'h02);

    // R9 exchange, R7 adjust
    clr(); pc = 0; mem['h321] = 8'hEE;
    ldk(8'h20); put(4'h3, 4'h3); put(4'h2, 4'h2); put(4'h6, 4'h0);
    put(4'h2, 4'h1); put(4'h6, 4'h1);
    put(4'hD, 4'h4); put(4'h3, 4'h6); put(4'h6, 4'h0);
    put(4'h1, 4'h0); put(4'hD, 4'hC); put(4'h3, 4'h8); put(4'h6, 4'h2);
    halt();
    run(16'h0000, 16'h0300, 50);
    chk("R9 wp from A,B", mem['h320], 'h03);
    chk("R9 B gets wp low", mem['h321], 'h00);
    chk("R7 positive adjust", mem['h324], 'h06);
    chk("R7 negative adjust", mem['h322], 'h08);

    // R5 branch conditions
    for (int i = 0; i < 4; i++) begin
      for (int kind = 0; kind < 2; kind++) begin
        logic [7:0] av;
        logic taken;
        av = vals[i];
        clr(); pc = 0; mem['h302] = 8'hEE;
        ldk(av); put(kind ? 4'hB : 4'hA, 4'h1); put(4'h6, 4'h2); halt();
        run(16'h0000, 16'h0300, 20);
        taken = kind ? !av[7] : (av != 8'h00);
        chk(kind ? "R5 sign branch" : "R5 nonzero branch", mem['h302], taken ? 'hEE : int'(av));
      end
    end
    for (int ci = 0; ci < 2; ci++) begin
      clr(); pc = 0; mem['h302] = 8'hEE;
      put(4'h2, ci ? 4'h5 : 4'h4); put(4'h3, 4'h5); put(4'hC, 4'h1); put(4'h6, 4'h2); halt();
      run(16'h0000, 16'h0300, 20);
      chk("R5 carry branch", mem['h302], ci ? 'h05 : 'hEE);
    end
    clr(); pc = 0; mem['h300] = 8'hFE;
    put(4'h2, 4'h4); put(4'h4, 4'h0); put(4'h3, 4'h1); put(4'h2, 4'h6);
    put(4'h6, 4'h0); put(4'h1, 4'h0); put(4'hC, 4'h9); halt();
    run(16'h0000, 16'h0300, 40);
    chk("R5 backward branch", mem['h300], 'h00);

    // R10 cycle costs from store strobe spacing
    for (int t = 0; t < 5; t++) begin
      int exp_gap;
      clr(); pc = 0;
      put(4'h3, 4'h1); put(4'h6, 4'h0);
      case (t)
        0: begin put(4'h3, 4'h2); exp_gap = 3; end
        1: begin put(4'h4, 4'h0); exp_gap = 4; end
        2: begin put(4'h0, 4'h1); put(4'h3, 4'h0); exp_gap = 4; end
        3: begin put(4'h5, 4'h0); exp_gap = 4; end
        default: begin put(4'hA, 4'h0); exp_gap = 3; end
      endcase
      put(4'h6, 4'h1); halt();
      run(16'h0000, 16'h0300, 20);
      chk("R10 strobe count", (we_n >= 2) ? 1 : 0, 1);
      chk("R10 instruction cycles", we_t[1] - we_t[0], exp_gap);
    end

    // R8 ALU sweep
    for (int oi = 0; oi < 11; oi++) begin
      for (int ia = 0; ia < 6; ia++) begin
        for (int ib = 0; ib < 6; ib++) begin
          for (int ci = 0; ci < 2; ci++) begin
            logic [8:0] ex;
            clr(); pc = 0;
            put(4'h2, ci ? 4'h5 : 4'h4);
            ldk(vals[ia]); ldk(vals[ib]);
            put(4'h2, 4'(ops[oi]));
            put(4'h6, 4'h0);
            ldk(8'h00); put(4'hC, 4'h1); put(4'h3, 4'h1); put(4'h6, 4'h1);
            halt();
            run(16'h0000, 16'h0300, 40);
            ex = alu_ref(ops[oi], vals[ib], vals[ia], ci[0]);
            chk("R8 alu result", mem['h300], int'(ex[7:0]));
            chk("R8 alu carry", mem['h301], int'(ex[8]));
          end
        end
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule